// File: doc/BRIEF.md
# Exception Prioritizer and Vector Generator

This block looks at every exception request raised in the current cycle and picks exactly one to take. The requests come from seven sources: reset, data abort, fast interrupt, normal interrupt, prefetch abort, undefined instruction and software interrupt. The two interrupt sources are gated by the current interrupt mask bits. For the winning source the block drives a take strobe, the vector address (a configurable base plus a fixed offset), a target mode code and the interrupt mask bits the core must load. It also drives a single strobe telling the core to capture its saved status and return address.

The decision is combinational, so a request and its vector appear in the same cycle. The only state is a one-bit pending flag. It is set when a data abort wins while an unmasked fast interrupt is also requested. On the next cycle the flag makes the fast interrupt win, even if the external request has already dropped. The fast interrupt therefore preempts the data abort handler before that handler runs any instruction, and the abort is still recorded first. Reset is asynchronous and wins over everything, including the masks. It also clears the pending flag at once.

Top module: `exc_arbiter`

## Requirements
- R1: While `exc_reset` is high, `take`=1, `vec_addr`=base+0x00, `mode`=1 (supervisor), `mask_i_out`=1, `mask_f_out`=1 and `save_ctx`=0, whatever the other inputs and masks are.
- R2: Priority from highest to lowest is reset, data abort, fast interrupt, normal interrupt, prefetch abort, then undefined instruction and software interrupt at one shared lowest level. These last two are never requested together.
- R3: The offsets added to the base are: data abort 0x10, fast interrupt 0x1C, normal interrupt 0x18, prefetch abort 0x0C, undefined instruction 0x04, software interrupt 0x08 and reset 0x00. The offset 0x14 is never produced.
- R4: The mode codes are: supervisor=1 for reset and software interrupt, abort=2 for both aborts, undef=3, irq=4 and fiq=5. `mode` is 0 when nothing is taken.
- R5: Any take sets `mask_i_out`. `mask_f_out` is set when reset or the fast interrupt is taken; for every other take it equals `mask_f`.
- R6: A normal interrupt request is ignored while `mask_i`=1, and a fast interrupt request is ignored while `mask_f`=1. A request that stays asserted is taken in the first cycle after its mask clears.
- R7: A data abort may win in a cycle where `req_fiq`=1 and `mask_f`=0. In that case the next cycle takes the fast interrupt (offset 0x1C, mode 5), even if `req_fiq` has dropped, unless a reset or another data abort arrives in that cycle. After the fast interrupt has been taken, the pending flag is cleared.
- R8: When nothing is taken: `take`=0, `save_ctx`=0, `vec_addr`=base, `mode`=0, and the mask outputs equal `mask_i` and `mask_f`.
- R9: `save_ctx` is high exactly when an exception other than reset is taken.
- R10: `vec_addr` is the parameter `VEC_BASE` plus the offset. The base must be 32-byte aligned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the pending fast-interrupt flag |
| exc_reset | input | 1 | Reset request, active high, asynchronous |
| req_dabt | input | 1 | Data abort request |
| req_fiq | input | 1 | Fast interrupt request |
| req_irq | input | 1 | Normal interrupt request |
| req_pabt | input | 1 | Prefetch abort request |
| req_und | input | 1 | Undefined instruction request |
| req_swi | input | 1 | Software interrupt request |
| mask_i | input | 1 | Current normal-interrupt mask |
| mask_f | input | 1 | Current fast-interrupt mask |
| take | output | 1 | An exception is taken this cycle |
| vec_addr | output | ADDR_W | Vector address of the chosen exception |
| mode | output | 3 | Target mode code |
| mask_i_out | output | 1 | Normal-interrupt mask to load |
| mask_f_out | output | 1 | Fast-interrupt mask to load |
| save_ctx | output | 1 | Capture saved status and return address |

## Verification
The hardest case to reach is the preemption of a data abort entry by a fast interrupt whose request has already gone. It needs a data abort and an unmasked fast interrupt in the same cycle, then a clock edge, then a cycle in which the fast interrupt request is low. In that later cycle the core has set the normal-interrupt mask and left the fast-interrupt mask clear. The bench builds this sequence directly and then checks the cycle after it, to confirm the pending flag is gone. Masked interrupts are covered the same way: a request is held across a cycle with its mask set and then across a cycle with the mask cleared.

// File: rtl/exc_pkg.sv
package exc_pkg;

   localparam int NUM_SRC = 7;

   // source index in priority order, 0 is highest
   localparam int SRC_RST  = 0;
   localparam int SRC_DABT = 1;
   localparam int SRC_FIQ  = 2;
   localparam int SRC_IRQ  = 3;
   localparam int SRC_PABT = 4;
   localparam int SRC_UND  = 5;
   localparam int SRC_SWI  = 6;

   typedef enum logic [2:0] {
      MODE_NONE = 3'd0,
      MODE_SVC  = 3'd1,
      MODE_ABT  = 3'd2,
      MODE_UND  = 3'd3,
      MODE_IRQ  = 3'd4,
      MODE_FIQ  = 3'd5
   } mode_t;

   function automatic logic [4:0] offset_of(input int idx);
      case (idx)
         SRC_DABT: offset_of = 5'h10;
         SRC_FIQ:  offset_of = 5'h1C;
         SRC_IRQ:  offset_of = 5'h18;
         SRC_PABT: offset_of = 5'h0C;
         SRC_UND:  offset_of = 5'h04;
         SRC_SWI:  offset_of = 5'h08;
         default:  offset_of = 5'h00;
      endcase
   endfunction

   function automatic mode_t mode_of(input int idx);
      case (idx)
         SRC_RST:  mode_of = MODE_SVC;
         SRC_DABT: mode_of = MODE_ABT;
         SRC_FIQ:  mode_of = MODE_FIQ;
         SRC_IRQ:  mode_of = MODE_IRQ;
         SRC_PABT: mode_of = MODE_ABT;
         SRC_UND:  mode_of = MODE_UND;
         SRC_SWI:  mode_of = MODE_SVC;
         default:  mode_of = MODE_NONE;
      endcase
   endfunction

endpackage

// File: rtl/exc_req_qual.sv
module exc_req_qual
   import exc_pkg::*;
#(
   parameter int HOLD_FIQ = 1
) (
   input  logic               clk,
   input  logic               exc_reset,
   input  logic               req_dabt,
   input  logic               req_fiq,
   input  logic               req_irq,
   input  logic               req_pabt,
   input  logic               req_und,
   input  logic               req_swi,
   input  logic               mask_i,
   input  logic               mask_f,
   input  logic [NUM_SRC-1:0] grant,
   output logic [NUM_SRC-1:0] qual_req
);

   logic fiq_pend;

   generate
      if (HOLD_FIQ != 0) begin : g_hold
         logic set_pend;
         assign set_pend = grant[SRC_DABT] & req_fiq & ~mask_f;
         always_ff @(posedge clk or posedge exc_reset) begin
            if (exc_reset)
               fiq_pend <= 1'b0;
            else if (grant[SRC_FIQ])
               fiq_pend <= 1'b0;
            else if (set_pend)
               fiq_pend <= 1'b1;
         end
      end else begin : g_nohold
         logic unused_ok;
         assign unused_ok = clk ^ grant[SRC_FIQ] ^ grant[SRC_DABT];
         assign fiq_pend  = 1'b0;
      end
   endgenerate

   always_comb begin
      qual_req           = '0;
      qual_req[SRC_RST]  = exc_reset;
      qual_req[SRC_DABT] = req_dabt;
      qual_req[SRC_FIQ]  = (req_fiq | fiq_pend) & ~mask_f;
      qual_req[SRC_IRQ]  = req_irq & ~mask_i;
      qual_req[SRC_PABT] = req_pabt;
      qual_req[SRC_UND]  = req_und;
      qual_req[SRC_SWI]  = req_swi;
   end

endmodule

// File: rtl/exc_pri_pick.sv
module exc_pri_pick #(
   parameter int N = 7
) (
   input  logic [N-1:0] req,
   output logic [N-1:0] grant,
   output logic         any
);

   logic [N:0] seen;

   assign seen[0] = 1'b0;

   generate
      for (genvar i = 0; i < N; i++) begin : g_chain
         assign grant[i]  = req[i] & ~seen[i];
         assign seen[i+1] = seen[i] | req[i];
      end
   endgenerate

   assign any = seen[N];

endmodule

// File: rtl/exc_vec_enc.sv
module exc_vec_enc
   import exc_pkg::*;
#(
   parameter int                ADDR_W   = 32,
   parameter logic [ADDR_W-1:0] VEC_BASE = '0
) (
   input  logic [NUM_SRC-1:0] grant,
   input  logic               any,
   input  logic               mask_i,
   input  logic               mask_f,
   output logic [ADDR_W-1:0]  vec_addr,
   output logic [2:0]         mode,
   output logic               mask_i_out,
   output logic               mask_f_out,
   output logic               save_ctx
);

   logic [4:0] off;
   mode_t      m;

   always_comb begin
      off = 5'h00;
      m   = MODE_NONE;
      for (int i = 0; i < NUM_SRC; i++) begin
         if (grant[i]) begin
            off = off | offset_of(i);
            m   = mode_t'(m | mode_of(i));
         end
      end
   end

   assign vec_addr   = VEC_BASE + ADDR_W'(off);
   assign mode       = m;
   assign mask_i_out = mask_i | any;
   assign mask_f_out = mask_f | grant[SRC_RST] | grant[SRC_FIQ];
   assign save_ctx   = any & ~grant[SRC_RST];

endmodule

// File: rtl/exc_arbiter.sv
module exc_arbiter
   import exc_pkg::*;
#(
   parameter int                ADDR_W   = 32,
   parameter logic [ADDR_W-1:0] VEC_BASE = '0,
   parameter int                HOLD_FIQ = 1
) (
   input  logic              clk,
   input  logic              exc_reset,
   input  logic              req_dabt,
   input  logic              req_fiq,
   input  logic              req_irq,
   input  logic              req_pabt,
   input  logic              req_und,
   input  logic              req_swi,
   input  logic              mask_i,
   input  logic              mask_f,
   output logic              take,
   output logic [ADDR_W-1:0] vec_addr,
   output logic [2:0]        mode,
   output logic              mask_i_out,
   output logic              mask_f_out,
   output logic              save_ctx
);

   localparam int TABLE_BYTES = 32;

   generate
      if (ADDR_W < 6) begin : g_bad_width
         $error("exc_arbiter: ADDR_W must be at least 6");
      end
      if (VEC_BASE % TABLE_BYTES != 0) begin : g_bad_base
         $error("exc_arbiter: VEC_BASE must be 32-byte aligned");
      end
      if (HOLD_FIQ != 0 && HOLD_FIQ != 1) begin : g_bad_hold
         $error("exc_arbiter: HOLD_FIQ must be 0 or 1");
      end
   endgenerate

   logic [NUM_SRC-1:0] qual_req;
   logic [NUM_SRC-1:0] grant;
   logic               any;

   exc_req_qual #(.HOLD_FIQ(HOLD_FIQ)) u_qual (
      .clk      (clk),
      .exc_reset(exc_reset),
      .req_dabt (req_dabt),
      .req_fiq  (req_fiq),
      .req_irq  (req_irq),
      .req_pabt (req_pabt),
      .req_und  (req_und),
      .req_swi  (req_swi),
      .mask_i   (mask_i),
      .mask_f   (mask_f),
      .grant    (grant),
      .qual_req (qual_req)
   );

   exc_pri_pick #(.N(NUM_SRC)) u_pick (
      .req  (qual_req),
      .grant(grant),
      .any  (any)
   );

   exc_vec_enc #(.ADDR_W(ADDR_W), .VEC_BASE(VEC_BASE)) u_enc (
      .grant     (grant),
      .any       (any),
      .mask_i    (mask_i),
      .mask_f    (mask_f),
      .vec_addr  (vec_addr),
      .mode      (mode),
      .mask_i_out(mask_i_out),
      .mask_f_out(mask_f_out),
      .save_ctx  (save_ctx)
   );

   assign take = any;

endmodule

// File: rtl/exc_arbiter_chk.sv
module exc_arbiter_chk #(
   parameter int                ADDR_W   = 32,
   parameter logic [ADDR_W-1:0] VEC_BASE = '0,
   parameter int                HOLD_FIQ = 1
) (
   input logic              clk,
   input logic              exc_reset,
   input logic              req_dabt,
   input logic              req_fiq,
   input logic              mask_i,
   input logic              mask_f,
   input logic              take,
   input logic [ADDR_W-1:0] vec_addr,
   input logic [2:0]        mode,
   input logic              mask_i_out,
   input logic              mask_f_out,
   input logic              save_ctx
);

   localparam logic [ADDR_W-1:0] A_DABT = VEC_BASE + ADDR_W'(16);
   localparam logic [ADDR_W-1:0] A_RSVD = VEC_BASE + ADDR_W'(20);

   p_reset_wins_r1: assert property (@(posedge clk)
      exc_reset |-> (take && vec_addr == VEC_BASE && mode == 3'd1 &&
                     mask_i_out && mask_f_out && !save_ctx));

   p_no_reserved_r3: assert property (@(posedge clk) disable iff (exc_reset)
      take |-> vec_addr != A_RSVD);

   p_i_mask_set_r5: assert property (@(posedge clk) disable iff (exc_reset)
      take |-> mask_i_out);

   p_dabt_keeps_f_r5: assert property (@(posedge clk) disable iff (exc_reset)
      (take && vec_addr == A_DABT) |-> (mask_f_out == mask_f));

   p_irq_unmasked_r6: assert property (@(posedge clk) disable iff (exc_reset)
      (take && mode == 3'd4) |-> !mask_i);

   p_fiq_unmasked_r6: assert property (@(posedge clk) disable iff (exc_reset)
      (take && mode == 3'd5) |-> !mask_f);

   p_fiq_after_dabt_r7: assert property (@(posedge clk) disable iff (exc_reset)
      ((HOLD_FIQ != 0) && take && vec_addr == A_DABT && req_fiq && !mask_f)
         |=> (req_dabt || (take && mode == 3'd5)));

   p_idle_pass_r8: assert property (@(posedge clk) disable iff (exc_reset)
      !take |-> (!save_ctx && mode == 3'd0 &&
                 mask_i_out == mask_i && mask_f_out == mask_f));

   p_save_on_take_r9: assert property (@(posedge clk) disable iff (exc_reset)
      save_ctx == take);

endmodule

bind exc_arbiter exc_arbiter_chk #(
   .ADDR_W  (ADDR_W),
   .VEC_BASE(VEC_BASE),
   .HOLD_FIQ(HOLD_FIQ)
) u_chk (
   .clk       (clk),
   .exc_reset (exc_reset),
   .req_dabt  (req_dabt),
   .req_fiq   (req_fiq),
   .mask_i    (mask_i),
   .mask_f    (mask_f),
   .take      (take),
   .vec_addr  (vec_addr),
   .mode      (mode),
   .mask_i_out(mask_i_out),
   .mask_f_out(mask_f_out),
   .save_ctx  (save_ctx)
);

// File: tb/exc_arbiter_test.sv
module exc_arbiter_test;

   localparam int          AW   = 32;
   localparam logic [31:0] BASE = 32'hFFFF_0000;

   logic clk = 1'b0;
   always #4 clk = ~clk;

   logic        exc_reset, req_dabt, req_fiq, req_irq, req_pabt, req_und, req_swi;
   logic        mask_i, mask_f;
   logic        take, mask_i_out, mask_f_out, save_ctx;
   logic [31:0] vec_addr;
   logic [2:0]  mode;

   exc_arbiter #(.ADDR_W(AW), .VEC_BASE(BASE), .HOLD_FIQ(1)) uut (
      .clk(clk), .exc_reset(exc_reset), .req_dabt(req_dabt), .req_fiq(req_fiq),
      .req_irq(req_irq), .req_pabt(req_pabt), .req_und(req_und), .req_swi(req_swi),
      .mask_i(mask_i), .mask_f(mask_f), .take(take), .vec_addr(vec_addr),
      .mode(mode), .mask_i_out(mask_i_out), .mask_f_out(mask_f_out),
      .save_ctx(save_ctx)
   );

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                      input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // inputs {rst,dabt,fiq,irq,pabt,und,swi, mi,mf} ; expected {take, off[4:0], mode[2:0], mi, mf}
   localparam int NV = 16;
   localparam logic [19:0] VEC [NV] = '{
      {7'b0000000, 2'b00, 1'b0, 5'h00, 3'd0, 2'b00},  // R8 idle
      {7'b0000000, 2'b11, 1'b0, 5'h00, 3'd0, 2'b11},  // R8 masks pass
      {7'b0000001, 2'b00, 1'b1, 5'h08, 3'd1, 2'b10},  // R3 R4 swi
      {7'b0000010, 2'b00, 1'b1, 5'h04, 3'd3, 2'b10},  // R3 R4 und
      {7'b0000100, 2'b01, 1'b1, 5'h0C, 3'd2, 2'b11},  // R5 pabt keeps F
      {7'b0001000, 2'b00, 1'b1, 5'h18, 3'd4, 2'b10},  // irq
      {7'b0010000, 2'b00, 1'b1, 5'h1C, 3'd5, 2'b11},  // R5 fiq sets F
      {7'b0100000, 2'b00, 1'b1, 5'h10, 3'd2, 2'b10},  // dabt
      {7'b0001110, 2'b00, 1'b1, 5'h18, 3'd4, 2'b10},  // R2 irq over pabt/und
      {7'b0001100, 2'b10, 1'b1, 5'h0C, 3'd2, 2'b10},  // R6 masked irq
      {7'b0011000, 2'b00, 1'b1, 5'h1C, 3'd5, 2'b11},  // R2 fiq over irq
      {7'b0011000, 2'b01, 1'b1, 5'h18, 3'd4, 2'b11},  // R6 masked fiq
      {7'b0110000, 2'b01, 1'b1, 5'h10, 3'd2, 2'b11},  // R2 dabt over masked fiq
      {7'b0101100, 2'b00, 1'b1, 5'h10, 3'd2, 2'b10},  // R2 dabt over irq/pabt
      {7'b0011000, 2'b11, 1'b0, 5'h00, 3'd0, 2'b11},  // R6 both masked
      {7'b1111111, 2'b00, 1'b1, 5'h00, 3'd1, 2'b11}   // R1 reset over all
   };

   task automatic drive(input logic [6:0] r, input logic [1:0] m);
      @(negedge clk);
      {exc_reset, req_dabt, req_fiq, req_irq, req_pabt, req_und, req_swi} = r;
      {mask_i, mask_f} = m;
      #2;
   endtask

   task automatic expect_out(input string tag, input bit t, input logic [4:0] off,
                             input logic [2:0] md, input logic [1:0] mo, input bit sv);
      chk(take == t, {tag, " take"}, 32'(take), 32'(t));
      chk(vec_addr == BASE + 32'(off), {tag, " vec R3 R10"}, vec_addr, BASE + 32'(off));
      chk(mode == md, {tag, " mode R4"}, 32'(mode), 32'(md));
      chk({mask_i_out, mask_f_out} == mo, {tag, " masks R5"},
          32'({mask_i_out, mask_f_out}), 32'(mo));
      chk(save_ctx == sv, {tag, " save R9"}, 32'(save_ctx), 32'(sv));
   endtask

   initial begin
      drive(7'b1000000, 2'b00);
      expect_out("R1 reset state", 1'b1, 5'h00, 3'd1, 2'b11, 1'b0);
      drive(7'b0000000, 2'b00);

      for (int i = 0; i < NV; i++) begin
         logic [19:0] v;
         v = VEC[i];
         drive(v[19:13], v[12:11]);
         expect_out($sformatf("R2 row %0d", i), v[10], v[9:5], v[4:2], v[1:0],
                    v[10] & ~v[19]);
      end
      drive(7'b0000000, 2'b00);

      // R7: data abort and fast interrupt together, fiq request then drops
      drive(7'b0110000, 2'b00);
      expect_out("R7 dabt first", 1'b1, 5'h10, 3'd2, 2'b10, 1'b1);
      drive(7'b0000000, 2'b10);
      expect_out("R7 fiq preempts", 1'b1, 5'h1C, 3'd5, 2'b11, 1'b1);
      drive(7'b0000000, 2'b10);
      expect_out("R7 pending cleared", 1'b0, 5'h00, 3'd0, 2'b10, 1'b0);

      // R6: held irq taken once unmasked
      drive(7'b0001000, 2'b10);
      expect_out("R6 irq held off", 1'b0, 5'h00, 3'd0, 2'b10, 1'b0);
      drive(7'b0001000, 2'b00);
      expect_out("R6 irq after unmask", 1'b1, 5'h18, 3'd4, 2'b10, 1'b1);

      // R7 + R1: reset clears the pending flag
      drive(7'b0110000, 2'b00);
      drive(7'b1000000, 2'b10);
      expect_out("R1 reset over pending", 1'b1, 5'h00, 3'd1, 2'b11, 1'b0);
      drive(7'b0000000, 2'b10);
      expect_out("R7 pending gone after reset", 1'b0, 5'h00, 3'd0, 2'b10, 1'b0);

      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      #400000;
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end

endmodule